// File: doc/BRIEF.md
# DDR Mode Register Programming Unit

This unit sits in the command-decode path on the memory side of a DDR SDRAM. It watches for a Mode Register Set command aimed at the base mode register and, when it sees one, it checks every field of the 13-bit address word. It stores the burst length, the burst type and the CAS latency only if the whole word is legal and all banks are idle. It then holds these settings until the next legal load or until reset. CAS latency is given out in half-clock units, so a latency of 2.5 clocks reads as 5.

The DLL-reset bit is never stored. A legal load that carries it produces a one-clock pulse and nothing more. Every accepted load opens a settle window of `BUSY_CYCLES` clocks, and the `busy` flag shows it. Any command to the register during that window is refused. A refused command leaves the stored settings as they were and raises a one-clock error pulse. A load is refused when the register is settling, when any bank is active, or when any field holds a reserved or unsupported code.

The control is a two-state machine:
- `ST_READY` is the state after reset. Its transition "accept" goes to `ST_SETTLE` on a legal load, and any other input holds it in `ST_READY`.
- `ST_SETTLE` holds while the wait timer runs. Its transition "expire" returns to `ST_READY` when the timer reaches zero.

Top module: `mrs_prog_unit`

## Requirements
- R1: After reset the unit reports burst length 2, sequential burst (`burst_interleave`=0) and `cas_half`=4. `busy`, `prog_error` and `dll_reset_pulse` are all 0.
- R2: Only `cmd_mrs`=1 with `bank_addr`=2'b00 addresses the register. With any other bank code the command is ignored: no error, no busy, and the stored settings do not change.
- R3: Address bits [2:0] select the burst length: 001 gives 2, 010 gives 4 and 011 gives 8. Any other code makes the whole load rejected.
- R4: Address bit 3 selects the burst type: 0 is sequential (`burst_interleave`=0) and 1 is interleaved (`burst_interleave`=1).
- R5: Address bits [6:4] select the CAS latency, reported on `cas_half` in half clocks. 010 gives 4, 011 gives 6 and 110 gives 5. Code 101 and every other code make the load rejected.
- R6: Address bits [12:7] select the operating mode: 000000 is normal and 000010 is DLL reset (A8 set). Any other value makes the load rejected.
- R7: A legal load with A8=1 drives `dll_reset_pulse` high for exactly the one clock after the load. A later legal load with A8=0 gives no pulse.
- R8: Stored settings do not change until the next accepted load.
- R9: A load while `banks_idle`=0 is rejected. The settings stay as they were and `busy` stays 0.
- R10: After each accepted load, `busy` is 1 for exactly `BUSY_CYCLES` clocks, starting in the clock after the load. A rejected command never raises `busy`.
- R11: A command to the register while `busy`=1 is rejected and does not change the settings.
- R12: Each rejected command raises `prog_error` for exactly the one clock after that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_mrs | input | 1 | Decoded Mode Register Set strobe, one clock |
| bank_addr | input | 2 | Bank-address bits for the command |
| addr | input | 13 | Address word carrying the mode fields |
| banks_idle | input | 1 | 1 when every bank is precharged |
| burst_len | output | 4 | Stored burst length (2, 4 or 8) |
| burst_interleave | output | 1 | Stored burst type, 1 for interleaved |
| cas_half | output | 4 | Stored CAS latency in half clocks |
| dll_reset_pulse | output | 1 | One-clock pulse when a load requests DLL reset |
| busy | output | 1 | Settle window after an accepted load |
| prog_error | output | 1 | One-clock pulse after a rejected command |

## Verification
The bench aims at the edges of each field. It drives every legal code, the unsupported latency 1.5 (code 101), and reserved codes in the burst length and the mode field. A decoder with an inverted table, or one that stored part of a word and rejected the rest, would leave different values on the outputs. The bench counts the exact length of the settle window. It also sends a command in the middle of that window. A timer that is off by one, or an FSM that returns too early, would let that command through or cut the window short. It also checks that a DLL-reset load pulses once and is not remembered, that commands to other banks are ignored without an error, and that a load while a bank is active is rejected.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    localparam int ADDR_W     = 13;
    localparam int BL_LSB     = 0;
    localparam int BT_BIT     = 3;
    localparam int CL_LSB     = 4;
    localparam int MODE_LSB   = 7;
    localparam int FIELD3_W   = 3;
    localparam int MODE_W     = ADDR_W - MODE_LSB;
    localparam int DLL_BIT    = 8;
    localparam int VAL_W      = 4;

    localparam logic [VAL_W-1:0] RST_BURST_LEN = 4'd2;
    localparam logic [VAL_W-1:0] RST_CAS_HALF  = 4'd4;

    typedef enum logic [0:0] {
        ST_READY  = 1'b0,
        ST_SETTLE = 1'b1
    } mrs_state_t;

    typedef struct packed {
        logic [VAL_W-1:0] burst_len;
        logic             interleave;
        logic [VAL_W-1:0] cas_half;
    } mrs_cfg_t;

endpackage

// File: rtl/mrs_field_decode.sv
module mrs_field_decode
    import mrs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output mrs_cfg_t          cfg,
    output logic              dll_rst,
    output logic              legal
);
    logic [FIELD3_W-1:0] bl_code;
    logic [FIELD3_W-1:0] cl_code;
    logic [MODE_W-1:0]   mode_code;
    logic                bl_ok;
    logic                cl_ok;
    logic                mode_ok;

    assign bl_code   = addr[BL_LSB +: FIELD3_W];
    assign cl_code   = addr[CL_LSB +: FIELD3_W];
    assign mode_code = addr[MODE_LSB +: MODE_W];

    always_comb begin
        bl_ok         = 1'b1;
        cfg.burst_len = RST_BURST_LEN;
        unique case (bl_code)
            3'b001:  cfg.burst_len = 4'd2;
            3'b010:  cfg.burst_len = 4'd4;
            3'b011:  cfg.burst_len = 4'd8;
            default: bl_ok = 1'b0;
        endcase
    end

    always_comb begin
        cl_ok        = 1'b1;
        cfg.cas_half = RST_CAS_HALF;
        unique case (cl_code)
            3'b010:  cfg.cas_half = 4'd4;
            3'b011:  cfg.cas_half = 4'd6;
            3'b110:  cfg.cas_half = 4'd5;
            default: cl_ok = 1'b0;
        endcase
    end

    assign cfg.interleave = addr[BT_BIT];

    // Normal mode is all zeros; DLL reset is the single bit A8.
    assign mode_ok = (mode_code == '0) ||
                     (mode_code == MODE_W'(1 << (DLL_BIT - MODE_LSB)));
    assign dll_rst = addr[DLL_BIT];
    assign legal   = bl_ok && cl_ok && mode_ok;

endmodule

// File: rtl/mrs_wait_timer.sv
module mrs_wait_timer #(
    parameter int BUSY_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BUSY_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= LOAD_VAL;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/mrs_cfg_store.sv
module mrs_cfg_store
    import mrs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  mrs_cfg_t wr_cfg,
    output mrs_cfg_t cfg
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.burst_len  <= RST_BURST_LEN;
            cfg.interleave <= 1'b0;
            cfg.cas_half   <= RST_CAS_HALF;
        end else if (wr_en) begin
            cfg <= wr_cfg;
        end
    end

endmodule

// File: rtl/mrs_prog_unit.sv
module mrs_prog_unit
    import mrs_pkg::*;
#(
    parameter int BUSY_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_mrs,
    input  logic [1:0]        bank_addr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              banks_idle,
    output logic [VAL_W-1:0]  burst_len,
    output logic              burst_interleave,
    output logic [VAL_W-1:0]  cas_half,
    output logic              dll_reset_pulse,
    output logic              busy,
    output logic              prog_error
);
    mrs_state_t state;
    mrs_state_t state_nxt;
    mrs_cfg_t   dec_cfg;
    mrs_cfg_t   cur_cfg;
    logic       dec_dll;
    logic       dec_legal;
    logic       hit;
    logic       accept;
    logic       reject;
    logic       timer_done;

    mrs_field_decode u_dec (
        .addr    (addr),
        .cfg     (dec_cfg),
        .dll_rst (dec_dll),
        .legal   (dec_legal)
    );

    assign hit    = cmd_mrs && (bank_addr == 2'b00);
    assign accept = hit && (state == ST_READY) && banks_idle && dec_legal;
    assign reject = hit && !accept;

    mrs_wait_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .expired (timer_done)
    );

    mrs_cfg_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (accept),
        .wr_cfg (dec_cfg),
        .cfg    (cur_cfg)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_READY:  if (accept)     state_nxt = ST_SETTLE;
            ST_SETTLE: if (timer_done) state_nxt = ST_READY;
            default:                   state_nxt = ST_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_READY;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_error      <= 1'b0;
            dll_reset_pulse <= 1'b0;
        end else begin
            prog_error      <= reject;
            dll_reset_pulse <= accept && dec_dll;
        end
    end

    assign busy             = (state == ST_SETTLE);
    assign burst_len        = cur_cfg.burst_len;
    assign burst_interleave = cur_cfg.interleave;
    assign cas_half         = cur_cfg.cas_half;

endmodule

// File: rtl/mrs_prog_checker.sv
module mrs_prog_checker #(
    parameter int BUSY_CYCLES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_mrs,
    input logic [1:0] bank_addr,
    input logic       banks_idle,
    input logic [3:0] burst_len,
    input logic       burst_interleave,
    input logic [3:0] cas_half,
    input logic       dll_reset_pulse,
    input logic       busy,
    input logic       prog_error
);
    logic [31:0] busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= '0;
    end

    // R2
    other_bank_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_mrs && bank_addr != 2'b00 && !busy) |=>
            (!prog_error && !busy && $stable(burst_len) &&
             $stable(cas_half) && $stable(burst_interleave)));

    // R7
    dll_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dll_reset_pulse |=> !dll_reset_pulse);

    // R8
    cfg_change_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(burst_len) || !$stable(cas_half) || !$stable(burst_interleave))
            |-> $rose(busy));

    // R9
    not_idle_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_mrs && bank_addr == 2'b00 && !banks_idle && !busy) |=>
            (prog_error && !busy));

    // R10
    busy_window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < BUSY_CYCLES));

    // R11
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_mrs && bank_addr == 2'b00 && busy) |=>
            (prog_error && $stable(cas_half) && $stable(burst_len)));

    // R12
    error_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_error |=> !prog_error || $past(cmd_mrs));

endmodule

bind mrs_prog_unit mrs_prog_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cmd_mrs          (cmd_mrs),
    .bank_addr        (bank_addr),
    .banks_idle       (banks_idle),
    .burst_len        (burst_len),
    .burst_interleave (burst_interleave),
    .cas_half         (cas_half),
    .dll_reset_pulse  (dll_reset_pulse),
    .busy             (busy),
    .prog_error       (prog_error)
);

// File: tb/tb_mrs_prog_unit.sv
module tb_mrs_prog_unit;
    localparam int BUSY = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_mrs = 1'b0;
    logic [1:0]  bank_addr = 2'b00;
    logic [12:0] addr = '0;
    logic        banks_idle = 1'b1;
    logic [3:0]  burst_len;
    logic        burst_interleave;
    logic [3:0]  cas_half;
    logic        dll_reset_pulse;
    logic        busy;
    logic        prog_error;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    logic [3:0] m_bl  = 4'd2;
    logic       m_bt  = 1'b0;
    logic [3:0] m_cas = 4'd4;

    always #4 clk = ~clk;

    mrs_prog_unit #(.BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_mrs(cmd_mrs), .bank_addr(bank_addr),
        .addr(addr), .banks_idle(banks_idle), .burst_len(burst_len),
        .burst_interleave(burst_interleave), .cas_half(cas_half),
        .dll_reset_pulse(dll_reset_pulse), .busy(busy), .prog_error(prog_error)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [12:0] mk(input logic [5:0] mode, input logic [2:0] cl,
                                       input logic bt, input logic [2:0] bl);
        return {mode, cl, bt, bl};
    endfunction

    task automatic check_cfg(input string req);
        check({req, " burst_len"}, burst_len, m_bl);
        check({req, " interleave"}, burst_interleave, m_bt);
        check({req, " cas_half"}, cas_half, m_cas);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // Issue one command; sample in the clock after it.
    task automatic issue(input logic [1:0] bank, input logic [12:0] a, input logic idle);
        @(negedge clk);
        cmd_mrs = 1'b1; bank_addr = bank; addr = a; banks_idle = idle;
        @(negedge clk);
        cmd_mrs = 1'b0; bank_addr = 2'b00; addr = '0; banks_idle = 1'b1;
    endtask

    // Legal load: model update, checks of R3..R7 and R10 window length.
    task automatic good_load(input string req, input logic [5:0] mode,
                             input logic [2:0] cl, input logic bt, input logic [2:0] bl,
                             input logic [3:0] exp_bl, input logic [3:0] exp_cas);
        int cnt;
        wait_idle();
        issue(2'b00, mk(mode, cl, bt, bl), 1'b1);
        m_bl = exp_bl; m_bt = bt; m_cas = exp_cas;
        check({req, " no error"}, prog_error, 0);
        check({req, " R7 dll pulse"}, dll_reset_pulse, mode[1]);
        check_cfg(req);
        cnt = 0;
        while (busy && cnt < 100) begin
            cnt++;
            @(negedge clk);
            if (cnt == 1) check("R7 pulse one clock", dll_reset_pulse, 0);
        end
        check("R10 busy length", cnt, BUSY);
    endtask

    // Rejected load: R12 one-clock error, no busy, no change.
    task automatic bad_load(input string req, input logic [1:0] bank,
                            input logic [12:0] a, input logic idle, input logic exp_err);
        wait_idle();
        issue(bank, a, idle);
        check({req, " error flag"}, prog_error, exp_err);
        check({req, " R10 no busy"}, busy, 0);
        check({req, " no dll pulse"}, dll_reset_pulse, 0);
        check_cfg(req);
        @(negedge clk);
        check("R12 error one clock", prog_error, 0);
    endtask

    task automatic t_reset();
        check("R1 burst_len", burst_len, 2);
        check("R1 interleave", burst_interleave, 0);
        check("R1 cas_half", cas_half, 4);
        check("R1 busy", busy, 0);
        check("R1 error", prog_error, 0);
        check("R1 dll", dll_reset_pulse, 0);
    endtask

    task automatic t_fields();
        good_load("R3 R5 bl4 cl2", 6'b0, 3'b010, 1'b0, 3'b010, 4'd4, 4'd4);
        good_load("R3 R4 R5 bl8 int cl3", 6'b0, 3'b011, 1'b1, 3'b011, 4'd8, 4'd6);
        good_load("R3 R5 bl2 cl2.5", 6'b0, 3'b110, 1'b0, 3'b001, 4'd2, 4'd5);
        good_load("R4 interleave bl4", 6'b0, 3'b011, 1'b1, 3'b010, 4'd4, 4'd6);
    endtask

    task automatic t_reserved();
        bad_load("R3 bl000", 2'b00, mk(6'b0, 3'b010, 1'b0, 3'b000), 1'b1, 1'b1);
        bad_load("R3 bl111", 2'b00, mk(6'b0, 3'b010, 1'b0, 3'b111), 1'b1, 1'b1);
        bad_load("R5 cl101", 2'b00, mk(6'b0, 3'b101, 1'b0, 3'b010), 1'b1, 1'b1);
        bad_load("R5 cl000", 2'b00, mk(6'b0, 3'b000, 1'b0, 3'b010), 1'b1, 1'b1);
        bad_load("R6 mode A7", 2'b00, mk(6'b000001, 3'b010, 1'b0, 3'b010), 1'b1, 1'b1);
        bad_load("R6 mode A12", 2'b00, mk(6'b100000, 3'b010, 1'b0, 3'b010), 1'b1, 1'b1);
    endtask

    task automatic t_dll();
        good_load("R6 R7 dll reset", 6'b000010, 3'b010, 1'b0, 3'b011, 4'd8, 4'd4);
        good_load("R7 no dll after", 6'b000000, 3'b010, 1'b1, 3'b011, 4'd8, 4'd4);
    endtask

    task automatic t_other_bank();
        bad_load("R2 bank01", 2'b01, mk(6'b0, 3'b011, 1'b0, 3'b001), 1'b1, 1'b0);
        bad_load("R2 bank10", 2'b10, mk(6'b0, 3'b011, 1'b0, 3'b001), 1'b1, 1'b0);
        bad_load("R2 bank11", 2'b11, mk(6'b0, 3'b011, 1'b0, 3'b001), 1'b1, 1'b0);
    endtask

    task automatic t_not_idle();
        bad_load("R9 bank active", 2'b00, mk(6'b0, 3'b110, 1'b0, 3'b010), 1'b0, 1'b1);
    endtask

    task automatic t_busy_reject();
        wait_idle();
        issue(2'b00, mk(6'b0, 3'b011, 1'b0, 3'b001), 1'b1);
        m_bl = 4'd2; m_bt = 1'b0; m_cas = 4'd6;
        check("R10 busy after load", busy, 1);
        // second command lands in the window
        cmd_mrs = 1'b1; addr = mk(6'b0, 3'b010, 1'b1, 3'b010);
        @(negedge clk);
        cmd_mrs = 1'b0; addr = '0;
        check("R11 error in window", prog_error, 1);
        check_cfg("R11");
        wait_idle();
        check("R12 error cleared", prog_error, 0);
    endtask

    task automatic t_retain();
        repeat (20) @(negedge clk);
        check_cfg("R8 retain");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_reserved();
        t_dll();
        t_other_bank();
        t_not_idle();
        t_busy_reject();
        t_retain();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule